// File: doc/BRIEF.md
# Access-Triggered Serial Management Master

This block lets a host reach the registers of an external PHY through the two-wire serial management interface (MDC clock plus a bidirectional MDIO line). The host first loads a target device number and a target register number into an address register. It then touches a 16-bit data register, and that touch launches the serial transaction on its own. There is no separate command or go bit.

A host write to the data register sends a write frame that carries the written value. A host read of the data register returns the value the register held before the access and sends a read frame. When that frame ends, the 16 bits that came back from the PHY replace the data register contents. Device number 31 is treated as invalid. An access that would target it produces no frame and raises an error flag instead.

The host side is a plain register port with single-cycle `host_wr` and `host_rd` strobes and combinational read-back, so there is no back-pressure. While `busy` is high, accesses to the data register are dropped. The address register can be rewritten at any time, because a running frame has already captured its fields. If `host_wr` and `host_rd` are both high in the same cycle, the access counts as a write.

Top module: `mdio_reg_master`

## Requirements
- R1: The address register (`host_sel`=0) keeps the device number in bits [9:5] and the register number in bits [4:0]. Bits [15:10] read back as zero, and writing them has no effect.
- R2: A write to the data register (`host_sel`=1) while idle, with a valid device number, stores the value in the data register. It also sends a 64-bit frame made of 32 ones, start bits 01, opcode 01, the device number MSB first, the register number MSB first, turnaround 10, and then the 16 data bits MSB first. `mdio_oe` stays high for all 64 bits.
- R3: A read of the data register while idle, with a valid device number, returns the current data register value on `host_rdata` during that access. It then sends a frame with opcode 10. `mdio_oe` is low for both turnaround bits and all 16 data bits. The 16 bits sampled MSB first are stored in the data register when the frame ends.
- R4: MDC has a period of 2*DIV_HALF system clocks. `mdio_o` and `mdio_oe` change only on edges after which MDC is low. Read data is sampled on the rising edge of MDC.
- R5: `busy` rises in the cycle after an accepted access and stays high until the frame ends. `mdio_oe` is never high while `busy` is low.
- R6: Data register accesses while `busy` is high are ignored. They start no frame, do not change the data register, and do not alter the frame in progress.
- R7: A data register access while the device number is 5'h1F starts no frame and leaves `busy` low and the data register unchanged. It sets `addr_err` in the next cycle. `addr_err` clears at the next accepted access.
- R8: Hard reset (`rst_n` low) clears the data register, `busy` and `addr_err`, and releases MDIO. The address register keeps its contents across hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset |
| host_sel | input | 1 | Register select: 0 address register, 1 data register |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read-back of the selected register |
| busy | output | 1 | Frame in progress |
| addr_err | output | 1 | Last data register access targeted the invalid device number |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
If the bit counter or the shift register goes wrong, a frame has the wrong length or its fields are misplaced. The PHY model catches this within the first 64 MDC periods. If the flags or the idle detection go wrong, an ignored access starts an extra frame, which shows as a second rising edge of `mdio_oe` a few MDC periods later. It can also show as a changed read-back one cycle after the access. If the read data path goes wrong, the read-back is wrong as soon as `busy` falls. Ordering faults in the drive timing show as an MDIO change while MDC is high, within one system cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SHIFT} mdio_state_e;

  typedef struct packed {
    logic [4:0] dev;
    logic [4:0] loc;
  } mdio_target_t;

  localparam logic [4:0] DEV_INVALID = 5'h1F;
  localparam logic [1:0] SOF_BITS    = 2'b01;
  localparam logic [1:0] OP_READ     = 2'b10;
  localparam logic [1:0] OP_WRITE    = 2'b01;
  localparam logic [1:0] TA_WRITE    = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_rd,
  input  mdio_target_t tgt,
  input  logic [15:0]  wdata,
  input  logic         rise_evt,
  input  logic         fall_evt,
  input  logic         mdio_i,
  output logic         busy,
  output logic         mdio_o,
  output logic         mdio_oe,
  output logic         rd_done,
  output logic [15:0]  rd_data
);
  localparam int FRAME   = PRE_LEN + 32;
  localparam int IW      = $clog2(FRAME);
  localparam int TA_IDX  = PRE_LEN + 14;
  localparam int DAT_IDX = PRE_LEN + 16;

  mdio_state_e      st_q;
  logic [FRAME-1:0] sh_q;
  logic [IW-1:0]    idx_q;
  logic [IW-1:0]    idx_nxt;
  logic             rd_q;
  logic             last_bit;

  assign busy     = (st_q != ST_IDLE);
  assign idx_nxt  = idx_q + 1'b1;
  assign last_bit = (idx_q == IW'(FRAME - 1));
  assign rd_done  = (st_q == ST_SHIFT) && fall_evt && last_bit && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            sh_q <= {{PRE_LEN{1'b1}}, SOF_BITS,
                     (is_rd ? OP_READ : OP_WRITE), tgt.dev, tgt.loc,
                     (is_rd ? 2'b00 : TA_WRITE),
                     (is_rd ? 16'h0000 : wdata)};
            rd_q <= is_rd;
            st_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (fall_evt) begin
            mdio_o  <= sh_q[FRAME-1];
            mdio_oe <= 1'b1;
            sh_q    <= sh_q << 1;
            idx_q   <= '0;
            st_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_evt && rd_q && (idx_q >= IW'(DAT_IDX)))
            rd_data <= {rd_data[14:0], mdio_i};
          if (fall_evt) begin
            if (last_bit) begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
              st_q    <= ST_IDLE;
            end else begin
              mdio_o  <= sh_q[FRAME-1];
              mdio_oe <= !(rd_q && (idx_nxt >= IW'(TA_IDX)));
              sh_q    <= sh_q << 1;
              idx_q   <= idx_nxt;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        busy,
  output logic        addr_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_target_t tgt_q;
  logic [15:0]  data_q;
  logic [15:0]  rd_data;
  logic         rd_done;
  logic         rise_evt;
  logic         fall_evt;
  logic         data_acc;
  logic         go;
  logic         bad;

  assign data_acc = host_sel && (host_wr || host_rd);
  assign go       = data_acc && !busy && (tgt_q.dev != DEV_INVALID);
  assign bad      = data_acc && !busy && (tgt_q.dev == DEV_INVALID);

  // Address register: deliberately outside hard reset.
  always_ff @(posedge clk) begin
    if (!host_sel && host_wr)
      tgt_q <= host_wdata[9:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      addr_err <= 1'b0;
    end else begin
      if (go && host_wr)
        data_q <= host_wdata;
      else if (rd_done)
        data_q <= rd_data;
      if (bad)
        addr_err <= 1'b1;
      else if (go)
        addr_err <= 1'b0;
    end
  end

  assign host_rdata = host_sel ? data_q : {6'b0, tgt_q};

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) clkgen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go),
    .is_rd    (!host_wr),
    .tgt      (tgt_q),
    .wdata    (host_wdata),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/mdio_chk.sv
module mdio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        addr_err,
  input logic [15:0] data_q
);
  assert_drive_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> !mdc);

  assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_data_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q));

  assert_err_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |-> !busy);
endmodule

bind mdio_reg_master mdio_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .busy     (busy),
  .addr_err (addr_err),
  .data_q   (data_q)
);

// File: tb/mdio_reg_master_tb.sv
`timescale 1ns/1ps
module mdio_reg_master_tb_top;
  localparam int DIV_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, addr_err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdio_reg_master #(.DIV_HALF(DIV_HALF), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .addr_err(addr_err), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_val = '0;
  int bitn = 64;
  int frames = 0;
  int drive_hi_viol = 0;
  logic prev_o = 1'b1, prev_oe = 1'b0;

  always @(posedge mdc) begin
    if ((bitn == 0 && mdio_oe) || (bitn > 0 && bitn < 64)) begin
      cap_o[63-bitn]  = mdio_o;
      cap_oe[63-bitn] = mdio_oe;
      bitn = bitn + 1;
    end
  end
  always @(negedge mdc)
    mdio_i = (bitn >= 48 && bitn < 64) ? phy_val[63-bitn] : 1'b1;
  always @(posedge mdio_oe) frames = frames + 1;
  always @(negedge clk) begin
    if (rst_n && ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) && mdc)
      drive_hi_viol = drive_hi_viol + 1;
    prev_o  = mdio_o;
    prev_oe = mdio_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] v);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [15:0] v);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] d,
                                            input logic [4:0] r, input logic [15:0] v);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), d, r,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : v)};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check(busy === 1'b0 && mdio_oe === 1'b0 && addr_err === 1'b0, "R8 reset flags",
          {busy, mdio_oe, addr_err}, 0);
    host_read(1'b1, v);
    wait_idle();
    check(v === 16'h0, "R8 reset data", v, 0);
  endtask

  task automatic t_addr_reg();
    logic [15:0] v;
    host_write(1'b0, 16'hFFFF);
    host_read(1'b0, v);
    check(v === 16'h03FF, "R1 reserved bits", v, 16'h03FF);
    host_write(1'b0, 16'hFC00 | {6'b0, 5'h0A, 5'h15});
    host_read(1'b0, v);
    check(v === {6'b0, 5'h0A, 5'h15}, "R1 field layout", v, {6'b0, 5'h0A, 5'h15});
  endtask

  task automatic t_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] val);
    logic [15:0] v;
    int f0;
    host_write(1'b0, {6'b0, d, r});
    f0 = frames; bitn = 0;
    host_write(1'b1, val);
    check(busy === 1'b1, "R5 busy after write", busy, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check(cap_o === exp_frame(1'b0, d, r, val), "R2 write frame", cap_o,
          exp_frame(1'b0, d, r, val));
    check(cap_oe === 64'hFFFF_FFFF_FFFF_FFFF, "R2 write oe", cap_oe, '1);
    check(frames == f0 + 1, "R5 one frame", frames, f0 + 1);
    host_read(1'b0, v); // no side effect
    bitn = 64;
  endtask

  task automatic t_read(input logic [4:0] d, input logic [4:0] r, input logic [15:0] pv);
    logic [15:0] old, v;
    host_write(1'b0, {6'b0, d, r});
    host_write(1'b1, 16'h5A5A); // set known old value
    wait_idle();
    phy_val = pv; bitn = 0;
    host_read(1'b1, old);
    check(old === 16'h5A5A, "R3 read returns old", old, 16'h5A5A);
    check(busy === 1'b1, "R5 busy after read", busy, 1);
    wait_idle();
    @(negedge clk);
    check(cap_o[63:18] === exp_frame(1'b1, d, r, 0) >> 18, "R3 read header",
          cap_o[63:18], exp_frame(1'b1, d, r, 0) >> 18);
    check(cap_oe === {46'h3FFF_FFFF_FFFF, 18'h0}, "R3 read release", cap_oe,
          {46'h3FFF_FFFF_FFFF, 18'h0});
    bitn = 64;
    host_write(1'b0, 16'h0);
    host_read(1'b0, v);
    host_write(1'b0, {6'b0, d, r});
    host_sel = 1'b1; #1 v = host_rdata;
    check(v === pv, "R3 read data latched", v, pv);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    int f0;
    host_write(1'b0, {6'b0, 5'h03, 5'h04});
    f0 = frames; bitn = 0;
    host_write(1'b1, 16'hA5A5);
    repeat (20) @(negedge clk);
    host_write(1'b1, 16'h1234);
    host_read(1'b1, v);
    check(v === 16'hA5A5, "R6 data unchanged while busy", v, 16'hA5A5);
    wait_idle();
    repeat (300) @(negedge clk);
    check(frames == f0 + 1, "R6 no extra frame", frames, f0 + 1);
    check(cap_o[15:0] === 16'hA5A5, "R6 frame data intact", cap_o[15:0], 16'hA5A5);
    bitn = 64;
  endtask

  task automatic t_invalid();
    logic [15:0] v;
    int f0;
    host_write(1'b0, {6'b0, 5'h1F, 5'h02});
    f0 = frames;
    host_write(1'b1, 16'hBEEF);
    check(addr_err === 1'b1 && busy === 1'b0, "R7 error no busy", {addr_err, busy}, 2'b10);
    host_read(1'b1, v);
    repeat (300) @(negedge clk);
    check(frames == f0, "R7 no frame", frames, f0);
    check(v === 16'hA5A5, "R7 data unchanged", v, 16'hA5A5);
    host_write(1'b0, {6'b0, 5'h1E, 5'h02});
    bitn = 0;
    host_write(1'b1, 16'h0F0F);
    check(addr_err === 1'b0, "R7 error cleared", addr_err, 0);
    wait_idle();
    bitn = 64;
  endtask

  task automatic t_mdc_period();
    time t0, t1;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check((t1 - t0) == 2 * DIV_HALF * 20, "R4 mdc period", t1 - t0, 2 * DIV_HALF * 20);
    check(drive_hi_viol == 0, "R4 drive while mdc low", drive_hi_viol, 0);
  endtask

  task automatic t_hard_reset();
    logic [15:0] v;
    host_write(1'b0, {6'b0, 5'h11, 5'h0C});
    host_write(1'b1, 16'h7777);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(busy === 1'b0 && mdio_oe === 1'b0, "R8 reset aborts", {busy, mdio_oe}, 0);
    host_read(1'b0, v);
    check(v === {6'b0, 5'h11, 5'h0C}, "R8 address kept", v, {6'b0, 5'h11, 5'h0C});
    host_sel = 1'b1; #1 v = host_rdata;
    check(v === 16'h0, "R8 data cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_reg();
    t_write(5'h0A, 5'h15, 16'h8001);
    t_write(5'h15, 5'h0A, 16'h7FFE);
    t_read(5'h01, 5'h1F, 16'hC3E7);
    t_read(5'h1E, 5'h00, 16'h0001);
    t_busy_ignore();
    t_invalid();
    t_mdc_period();
    t_hard_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule